// File: doc/BRIEF.md
# Programmable Clock Prescaler Tree

This block takes a single system clock and produces a family of divided clock-enable strobes that stay in one clock domain. Logic downstream keeps running on the system clock and acts only in the cycles when its strobe is high. It never sees a gated or derived clock. The tree has four levels:

- A main bus strobe is divided from the clock.
- Two peripheral-bus strobes, a tick-timer strobe and a storage-interface strobe are divided from the main bus strobe.
- Each peripheral path has a timer strobe.
- An ADC strobe is divided from the second peripheral-bus strobe.

Each programmable ratio comes from a small encoded select input. A new ratio takes effect only when the divider's current count period ends. A change of select therefore never produces a shortened or doubled interval between strobes. A strobe stays high for every cycle in which its divider wraps. With a ratio of 1 it follows its parent strobe exactly.

Top module: `clk_prescale_tree`

## Requirements
- R1: While `rst_n` is low, every strobe output is low. In the first clock cycle after reset is released, the main and peripheral-bus strobes assert. The ADC, tick and storage strobes do not.
- R2: The main divisor is selected by `main_sel`. Codes 0 to 4 give 1, 2, 4, 8 and 16. Codes 5 to 8 give 64, 128, 256 and 512. Codes 9 to 15 give 1. No code ever gives 32. The main strobe asserts once every divisor clock cycles.
- R3: Each peripheral-bus divisor is selected by its own 3-bit select. Codes 0 to 4 give 1, 2, 4, 8 and 16, and codes 5 to 7 give 1. The peripheral strobe period is the main period times that divisor.
- R4: When a peripheral divisor is 1, its timer strobe equals the peripheral strobe. Otherwise the timer strobe asserts twice per peripheral period, evenly spaced, and it asserts in every cycle where the peripheral strobe asserts.
- R5: `adc_sel` codes 0 to 3 divide the second peripheral-bus strobe by 2, 4, 6 and 8.
- R6: The tick strobe period is 8 main periods.
- R7: The storage strobe period is 2 main periods.
- R8: A new divisor is loaded only in a cycle where that divider's own strobe asserts. After a select change, each interval between strobes equals either the old period or the new period.
- R9: A strobe asserts only in a cycle where its parent strobe also asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_sel | input | 4 | Main bus divisor code |
| pbus1_sel | input | 3 | First peripheral-bus divisor code |
| pbus2_sel | input | 3 | Second peripheral-bus divisor code |
| adc_sel | input | 2 | ADC divisor code |
| main_stb | output | 1 | Main bus enable strobe |
| pbus1_stb | output | 1 | First peripheral-bus strobe |
| pbus2_stb | output | 1 | Second peripheral-bus strobe |
| tmr1_stb | output | 1 | Timer strobe of the first peripheral path |
| tmr2_stb | output | 1 | Timer strobe of the second peripheral path |
| adc_stb | output | 1 | ADC strobe |
| tick_stb | output | 1 | Tick-timer strobe |
| store_stb | output | 1 | Storage-interface strobe |

## Verification
The bench builds the block with its default parameters: a fixed tick ratio of 8, a storage ratio of 2, and a 10-bit counter width taken from the package. With these values the bench can exercise every code of every select, including the largest main divisor of 512 and the unused codes that fall back to the default divisor. Because the counters are 10 bits wide, a ratio applied in the middle of a period would show up as an interval far outside the allowed pair of values. The timer doubling rule and the uneven ADC divisor of 6 are reached with short main periods, so each ratio is measured over several strobes.

// File: rtl/clkpre_pkg.sv
package clkpre_pkg;

  localparam int MAIN_SEL_W = 4;
  localparam int BUS_SEL_W  = 3;
  localparam int ADC_SEL_W  = 2;
  localparam int DIV_W      = 10;

  typedef logic [DIV_W-1:0] div_t;

  // Main ratio: powers of two, with the 32 step skipped.
  function automatic div_t main_div_decode(input logic [MAIN_SEL_W-1:0] code);
    div_t r;
    if (code <= 4'd4)      r = div_t'(1) << code;
    else if (code <= 4'd8) r = div_t'(1) << (code + 4'd1);
    else                   r = div_t'(1);
    return r;
  endfunction

  function automatic div_t bus_div_decode(input logic [BUS_SEL_W-1:0] code);
    div_t r;
    if (code <= 3'd4) r = div_t'(1) << code;
    else              r = div_t'(1);
    return r;
  endfunction

  // ADC ratio: even steps 2..8.
  function automatic div_t adc_div_decode(input logic [ADC_SEL_W-1:0] code);
    return div_t'({code, 1'b0}) + div_t'(2);
  endfunction

endpackage

// File: rtl/cpt_strobe_div.sv
module cpt_strobe_div #(
  parameter int W       = 10,
  parameter int RST_DIV = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         parent_stb,
  input  logic [W-1:0] req_div,
  output logic         stb,
  output logic         mid_stb,
  output logic [W-1:0] div_now
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] div_q;
  logic [W-1:0] last_cnt;
  logic [W-1:0] half_cnt;
  logic [W-1:0] next_div;
  logic         wrap;

  assign last_cnt = div_q - W'(1);
  assign half_cnt = (div_q >> 1) - W'(1);
  assign wrap     = (cnt_q == last_cnt);
  assign next_div = (req_div == '0) ? W'(1) : req_div;

  assign stb     = parent_stb & wrap;
  assign mid_stb = parent_stb & (div_q > W'(1)) & (cnt_q == half_cnt);
  assign div_now = div_q;

  // The divisor is reloaded only when the period ends.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= W'(RST_DIV);
    end else if (parent_stb) begin
      if (wrap) begin
        cnt_q <= '0;
        div_q <= next_div;
      end else begin
        cnt_q <= cnt_q + W'(1);
      end
    end
  end

endmodule

// File: rtl/clk_prescale_tree.sv
module clk_prescale_tree
  import clkpre_pkg::*;
#(
  parameter int TICK_DIV  = 8,
  parameter int STORE_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [MAIN_SEL_W-1:0] main_sel,
  input  logic [BUS_SEL_W-1:0]  pbus1_sel,
  input  logic [BUS_SEL_W-1:0]  pbus2_sel,
  input  logic [ADC_SEL_W-1:0]  adc_sel,
  output logic                  main_stb,
  output logic                  pbus1_stb,
  output logic                  pbus2_stb,
  output logic                  tmr1_stb,
  output logic                  tmr2_stb,
  output logic                  adc_stb,
  output logic                  tick_stb,
  output logic                  store_stb
);

  localparam int NBUS = 2;

  logic run_q;
  logic main_mid;
  div_t main_div_now;

  logic [BUS_SEL_W-1:0] bus_sel [NBUS];
  logic [NBUS-1:0]      bus_stb;
  logic [NBUS-1:0]      bus_mid;
  logic [NBUS-1:0]      tmr_stb;
  div_t                 bus_div_now [NBUS];

  logic adc_mid, tick_mid, store_mid;
  div_t adc_div_now, tick_div_now, store_div_now;

  // Strobes start one cycle after reset release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  cpt_strobe_div #(.W(DIV_W), .RST_DIV(1)) u_main (
    .clk(clk), .rst_n(rst_n), .parent_stb(run_q),
    .req_div(main_div_decode(main_sel)),
    .stb(main_stb), .mid_stb(main_mid), .div_now(main_div_now)
  );

  assign bus_sel[0] = pbus1_sel;
  assign bus_sel[1] = pbus2_sel;

  for (genvar b = 0; b < NBUS; b++) begin : g_bus
    cpt_strobe_div #(.W(DIV_W), .RST_DIV(1)) u_bus (
      .clk(clk), .rst_n(rst_n), .parent_stb(main_stb),
      .req_div(bus_div_decode(bus_sel[b])),
      .stb(bus_stb[b]), .mid_stb(bus_mid[b]), .div_now(bus_div_now[b])
    );
    // Half-period strobe exists only when the divisor exceeds 1.
    assign tmr_stb[b] = bus_stb[b] | bus_mid[b];
  end

  assign pbus1_stb = bus_stb[0];
  assign pbus2_stb = bus_stb[1];
  assign tmr1_stb  = tmr_stb[0];
  assign tmr2_stb  = tmr_stb[1];

  cpt_strobe_div #(.W(DIV_W), .RST_DIV(2)) u_adc (
    .clk(clk), .rst_n(rst_n), .parent_stb(bus_stb[1]),
    .req_div(adc_div_decode(adc_sel)),
    .stb(adc_stb), .mid_stb(adc_mid), .div_now(adc_div_now)
  );

  cpt_strobe_div #(.W(DIV_W), .RST_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .parent_stb(main_stb),
    .req_div(DIV_W'(TICK_DIV)),
    .stb(tick_stb), .mid_stb(tick_mid), .div_now(tick_div_now)
  );

  cpt_strobe_div #(.W(DIV_W), .RST_DIV(STORE_DIV)) u_store (
    .clk(clk), .rst_n(rst_n), .parent_stb(main_stb),
    .req_div(DIV_W'(STORE_DIV)),
    .stb(store_stb), .mid_stb(store_mid), .div_now(store_div_now)
  );

endmodule

// File: rtl/clk_prescale_tree_chk.sv
module clk_prescale_tree_chk #(
  parameter int W         = 10,
  parameter int TICK_DIV  = 8,
  parameter int STORE_DIV = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         main_stb,
  input logic         pbus1_stb,
  input logic         pbus2_stb,
  input logic         tmr1_stb,
  input logic         tmr2_stb,
  input logic         adc_stb,
  input logic         tick_stb,
  input logic         store_stb,
  input logic         main_mid,
  input logic         adc_mid,
  input logic         tick_mid,
  input logic         store_mid,
  input logic [W-1:0] main_div_now,
  input logic [W-1:0] adc_div_now,
  input logic [W-1:0] tick_div_now,
  input logic [W-1:0] store_div_now
);

  // R1
  r1_quiet_in_reset_chk: assert property (@(posedge clk)
    !rst_n |-> !(main_stb | pbus1_stb | pbus2_stb | tmr1_stb | tmr2_stb |
                 adc_stb | tick_stb | store_stb));

  // R2
  r2_main_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(main_div_now) == 1) && (main_div_now != W'(32)));

  // R4
  r4_tmr1_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pbus1_stb |-> tmr1_stb);

  // R4
  r4_tmr2_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pbus2_stb |-> tmr2_stb);

  // R5
  r5_adc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_div_now[0] && (adc_div_now >= W'(2)) && (adc_div_now <= W'(8)));

  // R6
  r6_tick_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_div_now == W'(TICK_DIV));

  // R7
  r7_store_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_div_now == W'(STORE_DIV));

  // R8
  r8_main_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(main_div_now) |-> $past(main_stb));

  // R8
  r8_adc_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(adc_div_now) |-> $past(adc_stb));

  // R9
  r9_pbus_parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pbus1_stb | pbus2_stb | tmr1_stb | tmr2_stb) |-> main_stb);

  // R9
  r9_adc_parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_stb | adc_mid) |-> pbus2_stb);

  // R9
  r9_fixed_parent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_stb | tick_mid | store_stb | store_mid) |-> main_stb);

  // R9
  r9_main_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_mid |-> !main_stb);

endmodule

bind clk_prescale_tree clk_prescale_tree_chk #(
  .W(clkpre_pkg::DIV_W), .TICK_DIV(TICK_DIV), .STORE_DIV(STORE_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .main_stb(main_stb), .pbus1_stb(pbus1_stb), .pbus2_stb(pbus2_stb),
  .tmr1_stb(tmr1_stb), .tmr2_stb(tmr2_stb), .adc_stb(adc_stb),
  .tick_stb(tick_stb), .store_stb(store_stb),
  .main_mid(main_mid), .adc_mid(adc_mid), .tick_mid(tick_mid),
  .store_mid(store_mid),
  .main_div_now(main_div_now), .adc_div_now(adc_div_now),
  .tick_div_now(tick_div_now), .store_div_now(store_div_now)
);

// File: tb/tb_clk_prescale_tree.sv
`timescale 1ns/1ps
module tb_clk_prescale_tree;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] main_sel = '0;
  logic [2:0] pbus1_sel = '0;
  logic [2:0] pbus2_sel = '0;
  logic [1:0] adc_sel = '0;
  logic main_stb, pbus1_stb, pbus2_stb, tmr1_stb, tmr2_stb;
  logic adc_stb, tick_stb, store_stb;

  always #2 clk = ~clk;

  clk_prescale_tree dut (
    .clk(clk), .rst_n(rst_n), .main_sel(main_sel),
    .pbus1_sel(pbus1_sel), .pbus2_sel(pbus2_sel), .adc_sel(adc_sel),
    .main_stb(main_stb), .pbus1_stb(pbus1_stb), .pbus2_stb(pbus2_stb),
    .tmr1_stb(tmr1_stb), .tmr2_stb(tmr2_stb), .adc_stb(adc_stb),
    .tick_stb(tick_stb), .store_stb(store_stb)
  );

  int errors = 0;
  int checks = 0;

  // Index 0 main, 1 pbus1, 2 pbus2, 3 tmr1, 4 tmr2, 5 adc, 6 tick, 7 store
  logic [7:0] s;
  assign s = {store_stb, tick_stb, adc_stb, tmr2_stb, tmr1_stb,
              pbus2_stb, pbus1_stb, main_stb};

  int cyc = 0;
  int n [8];
  int mn [8];
  int mx [8];
  int last [8];
  bit seen [8];
  int odd = 0;
  int allow_a = 0;
  int allow_b = 0;
  int hier_bad = 0;
  int tmr_bad = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      for (int i = 0; i < 8; i++) begin
        if (s[i]) begin
          if (seen[i]) begin
            if (cyc - last[i] < mn[i]) mn[i] = cyc - last[i];
            if (cyc - last[i] > mx[i]) mx[i] = cyc - last[i];
            if (i == 0 && (cyc - last[i]) != allow_a && (cyc - last[i]) != allow_b)
              odd = odd + 1;
          end
          seen[i] = 1'b1;
          last[i] = cyc;
          n[i] = n[i] + 1;
        end
      end
      if ((s[1] | s[2] | s[3] | s[4] | s[6] | s[7]) & !s[0]) hier_bad = hier_bad + 1;
      if (s[5] & !s[2]) hier_bad = hier_bad + 1;
      if ((s[1] & !s[3]) | (s[2] & !s[4])) tmr_bad = tmr_bad + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stats(input bit keep_last);
    for (int i = 0; i < 8; i++) begin
      n[i] = 0; mn[i] = 1 << 20; mx[i] = 0;
      if (!keep_last) seen[i] = 1'b0;
    end
    odd = 0;
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic wait_strobes(input int idx, input int need, input int limit);
    for (int k = 0; k < limit && n[idx] < need; k++) @(posedge clk);
    #1;
  endtask

  // Bench-side restatement of the divisor codes
  function automatic int exp_main(input int code);
    case (code)
      0: return 1;   1: return 2;   2: return 4;   3: return 8;
      4: return 16;  5: return 64;  6: return 128; 7: return 256;
      8: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_bus(input int code);
    case (code)
      1: return 2; 2: return 4; 3: return 8; 4: return 16;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_tmr(input int mper, input int b);
    return (b == 1) ? mper : (mper * b) / 2;
  endfunction

  task automatic check_period(input int idx, input int per, input string req);
    clear_stats(1'b0);
    wait_strobes(idx, 3, per * 4 + 20);
    check(n[idx] >= 3 && mn[idx] == per && mx[idx] == per, req,
          (n[idx] >= 3) ? mx[idx] : -n[idx], per);
    if (mn[idx] != mx[idx] && n[idx] >= 3)
      $display("  min gap %0d on index %0d", mn[idx], idx);
  endtask

  task automatic t_reset();
    logic [7:0] seen_any;
    seen_any = '0;
    rst_n = 1'b0;
    main_sel = 4'd2;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      seen_any = seen_any | s;
    end
    // R1: quiet while held in reset
    check(seen_any == 8'h00, "R1 quiet in reset", int'(seen_any), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: first running cycle, smallest divisors in force
    check(s == 8'b0001_1111, "R1 first cycle strobes", int'(s), 8'h1f);
    step(1);
  endtask

  task automatic t_main_codes();
    pbus1_sel = 3'd0; pbus2_sel = 3'd0;
    for (int c = 0; c < 16; c++) begin
      main_sel = 4'(c);
      step(1100);
      // R2: main period per code, unused codes give 1
      check_period(0, exp_main(c), $sformatf("R2 main code %0d", c));
    end
  endtask

  task automatic t_bus_codes();
    main_sel = 4'd1;
    for (int c = 0; c < 8; c++) begin
      pbus1_sel = 3'(c);
      pbus2_sel = 3'(7 - c);
      step(120);
      // R3: bus period is main period times bus divisor
      check_period(1, 2 * exp_bus(c), $sformatf("R3 pbus1 code %0d", c));
      check_period(2, 2 * exp_bus(7 - c), $sformatf("R3 pbus2 code %0d", 7 - c));
      // R4: timer runs at 1x for divisor 1, else 2x
      check_period(3, exp_tmr(2, exp_bus(c)), $sformatf("R4 tmr1 code %0d", c));
      check_period(4, exp_tmr(2, exp_bus(7 - c)), $sformatf("R4 tmr2 code %0d", 7 - c));
    end
  endtask

  task automatic t_adc_codes();
    main_sel = 4'd0;
    pbus2_sel = 3'd1;
    for (int c = 0; c < 4; c++) begin
      adc_sel = 2'(c);
      step(100);
      // R5: ADC divides pbus2 by 2,4,6,8
      check_period(5, 2 * (2 * c + 2), $sformatf("R5 adc code %0d", c));
    end
    pbus2_sel = 3'd2;
    adc_sel = 2'd2;
    step(120);
    check_period(5, 4 * 6, "R5 adc div6 on pbus2 div4");
  endtask

  task automatic t_fixed();
    main_sel = 4'd0;
    step(40);
    // R6 and R7 at main divisor 1
    check_period(6, 8, "R6 tick main div1");
    check_period(7, 2, "R7 store main div1");
    main_sel = 4'd2;
    step(80);
    check_period(6, 32, "R6 tick main div4");
    check_period(7, 8, "R7 store main div4");
  endtask

  task automatic t_switch(input int from_code, input int to_code);
    main_sel = 4'(from_code);
    step(1100);
    clear_stats(1'b0);
    wait_strobes(0, 1, 600);
    step(3);
    allow_a = exp_main(from_code);
    allow_b = exp_main(to_code);
    clear_stats(1'b1);
    main_sel = 4'(to_code);
    wait_strobes(0, 8, 2000);
    // R8: only old or new period lengths appear across the change
    check(odd == 0 && n[0] >= 8, $sformatf("R8 no runt %0d->%0d", allow_a, allow_b), odd, 0);
    check(mx[0] == ((allow_a > allow_b) ? allow_a : allow_b) &&
          mn[0] == ((allow_a < allow_b) ? allow_a : allow_b),
          $sformatf("R8 span %0d->%0d", allow_a, allow_b), mx[0],
          (allow_a > allow_b) ? allow_a : allow_b);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    clear_stats(1'b0);
    t_reset();
    t_main_codes();
    t_bus_codes();
    t_adc_codes();
    t_fixed();
    t_switch(3, 1);
    t_switch(1, 4);
    t_switch(0, 5);
    // R9: children only with parents; R4: timer covers its bus strobe
    check(hier_bad == 0, "R9 parent coincidence", hier_bad, 0);
    check(tmr_bad == 0, "R4 timer coincidence", tmr_bad, 0);
    finish_run();
  end

endmodule